// File: doc/BRIEF.md
# ROM-programmed message sequencer

This block runs a short byte program stored in a constant ROM and turns it into a byte stream for a UART transmitter. The program is a list of instructions of three kinds: a pause whose length is counted in prescaled ticks, a text string that is streamed out character by character, and a stop that freezes the sequencer. Pauses and strings can appear in any order. A typical program starts with a pause of at least one character time, so that a receiver on the far side of the serial line sees an idle line before the first character arrives. It then alternates strings and pauses and ends with a stop.

Each character goes to the transmitter over a valid/ready handshake. The program counter is as wide as the ROM address parameter and starts at address 0 after reset. The ROM takes one cycle to read, so every opcode, operand or character is fetched in one cycle and acted on in the next. The parameter `PROG_SEL` selects one of two built-in programs. The parameter `TICK_DIV` sets the number of clock cycles in one pause unit.

Top module: `byteprog_seq`

## Requirements
- R1: While `rst_n` is low, `tx_valid` and `halted` are 0. The first instruction is read from address 0, and its opcode is acted on in the cycle after the first clock edge at which `rst_n` is high.
- R2: Opcode 0xF1 takes a one-byte operand N. The next opcode is acted on exactly 4 + N·TICK_DIV cycles after the pause opcode was acted on. No byte is offered during that time, and N = 0 gives no pause beyond those 4 cycles.
- R3: Opcode 0xF2 is followed by characters, and these are offered in ROM order up to a 0x00 terminator. The terminator is never offered. The first character is offered 3 cycles after the opcode is acted on. The next opcode is acted on 4 cycles after the last character's handshake, or 4 cycles after an empty string's opcode.
- R4: An offered character keeps `tx_valid` high and `tx_data` unchanged until the first clock edge at which `tx_ready` is high. `tx_valid` falls after that edge, and the next character is offered 2 cycles after it.
- R5: Opcode 0xF0 raises `halted` one cycle after it is acted on. `halted` then stays high and no further byte is ever offered, even if bytes follow the stop in the ROM.
- R6: Any opcode byte other than 0xF0, 0xF1 or 0xF2 is treated exactly like 0xF0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | output | 8 | Character offered to the transmitter |
| tx_valid | output | 1 | A character is offered on `tx_data` |
| tx_ready | input | 1 | The transmitter accepts the offered character at this edge |
| halted | output | 1 | The sequencer has stopped for good |

## Verification
Every result has a fixed delay that can be counted from the cycle in which an opcode is acted on. A pause hands over after 4 + N·TICK_DIV cycles, the first character of a string appears after 3 cycles, a character follows a handshake after 2 cycles, the step past a terminator takes 4 cycles, and `halted` rises after 1 cycle. The bench's reference model walks its own copy of each program and waits exactly those cycle counts. It reads `tx_ready` just after each rising edge, so it knows at which edge each handshake completed. The outputs are compared with the model on every falling edge. One copy of the design runs a program that ends in the stop opcode, and a second copy runs a program that ends in an undefined byte. Both copies run against an irregular ready pattern.

// File: rtl/byteprog_pkg.sv
// Shared constants and types for the byte-program sequencer.
// Assumes opcode and terminator values are distinct single bytes.
package byteprog_pkg;

    localparam logic [7:0] OPC_PAUSE = 8'hF1;
    localparam logic [7:0] OPC_TEXT  = 8'hF2;
    localparam logic [7:0] OPC_STOP  = 8'hF0;
    localparam logic [7:0] TEXT_END  = 8'h00;

    typedef enum logic [2:0] {
        ST_OPF  = 3'd0,  // opcode read in flight
        ST_OP   = 3'd1,  // opcode on ROM output, decode
        ST_ARGF = 3'd2,  // pause operand read in flight
        ST_ARG  = 3'd3,  // pause operand on ROM output
        ST_WAIT = 3'd4,  // counting pause ticks
        ST_CHF  = 3'd5,  // character read in flight
        ST_CH   = 3'd6,  // character on ROM output
        ST_TX   = 3'd7   // character offered, awaiting ready
    } seq_state_t;

endpackage

// File: rtl/byteprog_rom.sv
// Constant program ROM with one cycle of read latency.
// PROG_SEL picks one of two built-in programs; addresses beyond a
// program read as 0x00, which decodes as an undefined opcode.
module byteprog_rom #(
    parameter int ADDR_W   = 9,
    parameter int PROG_SEL = 0
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rdata
);

    // Program 0: pause, text, zero pause, empty text, pause, text, stop.
    function automatic logic [7:0] prog_main(input logic [ADDR_W-1:0] a);
        case (int'(a))
            0:  return 8'hF1;
            1:  return 8'h03;
            2:  return 8'hF2;
            3:  return 8'h48;
            4:  return 8'h69;
            5:  return 8'h00;
            6:  return 8'hF1;
            7:  return 8'h00;
            8:  return 8'hF2;
            9:  return 8'h00;
            10: return 8'hF1;
            11: return 8'h01;
            12: return 8'hF2;
            13: return 8'h47;
            14: return 8'h6F;
            15: return 8'h21;
            16: return 8'h00;
            17: return 8'hF0;
            18: return 8'hF2;
            19: return 8'h58;
            20: return 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    // Program 1: pause, text, then an undefined opcode before more text.
    function automatic logic [7:0] prog_alt(input logic [ADDR_W-1:0] a);
        case (int'(a))
            0: return 8'hF1;
            1: return 8'h02;
            2: return 8'hF2;
            3: return 8'h41;
            4: return 8'h62;
            5: return 8'h00;
            6: return 8'h7E;
            7: return 8'hF2;
            8: return 8'h5A;
            9: return 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    generate
        if (PROG_SEL == 0) begin : g_main
            // Registered read of the main program.
            always_ff @(posedge clk) rdata <= prog_main(addr);
        end else begin : g_alt
            // Registered read of the alternate program.
            always_ff @(posedge clk) rdata <= prog_alt(addr);
        end
    endgenerate

endmodule

// File: rtl/byteprog_tick.sv
// Prescaler that yields a one-cycle tick every DIV cycles.
// A clear restarts the count so the first tick follows DIV cycles later.
module byteprog_tick #(
    parameter int DIV = 8680
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count cycles, wrapping on tick and restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/byteprog_ctrl.sv
// Fetch/execute controller: walks the program counter over the ROM,
// decodes opcodes, times pauses and streams text with valid/ready.
// Assumes the ROM output reflects the address of the previous cycle.
module byteprog_ctrl
    import byteprog_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rom_q,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              tick,
    output logic              tick_clr,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              halted,
    output seq_state_t        state_o,
    output logic [7:0]        dcnt_o
);

    seq_state_t        st;
    logic              stop_q;
    logic [ADDR_W-1:0] pc;
    logic [7:0]        dcnt;

    assign rom_addr = pc;
    assign tick_clr = (st == ST_ARG);
    assign halted   = stop_q;
    assign state_o  = st;
    assign dcnt_o   = dcnt;

    // Sequencer state, program counter, pause count and output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OPF;
            stop_q   <= 1'b0;
            pc       <= '0;
            dcnt     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (!stop_q) begin
            case (st)
                ST_OPF: st <= ST_OP;
                ST_OP: begin
                    if (rom_q == OPC_PAUSE) begin
                        pc <= pc + 1'b1;
                        st <= ST_ARGF;
                    end else if (rom_q == OPC_TEXT) begin
                        pc <= pc + 1'b1;
                        st <= ST_CHF;
                    end else begin
                        stop_q <= 1'b1;
                    end
                end
                ST_ARGF: st <= ST_ARG;
                ST_ARG: begin
                    dcnt <= rom_q;
                    pc   <= pc + 1'b1;
                    st   <= (rom_q == 8'd0) ? ST_OPF : ST_WAIT;
                end
                ST_WAIT: begin
                    if (tick) begin
                        dcnt <= dcnt - 1'b1;
                        if (dcnt == 8'd1) begin
                            st <= ST_OPF;
                        end
                    end
                end
                ST_CHF: st <= ST_CH;
                ST_CH: begin
                    if (rom_q == TEXT_END) begin
                        pc <= pc + 1'b1;
                        st <= ST_OPF;
                    end else begin
                        tx_data  <= rom_q;
                        tx_valid <= 1'b1;
                        st       <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (tx_ready) begin
                        tx_valid <= 1'b0;
                        pc       <= pc + 1'b1;
                        st       <= ST_CHF;
                    end
                end
                default: st <= ST_OPF;
            endcase
        end
    end

endmodule

// File: rtl/byteprog_seq.sv
// Top of the byte-program sequencer: ROM, tick prescaler, controller.
// TICK_DIV is the pause unit in clock cycles (at least 2).
module byteprog_seq #(
    parameter int ADDR_W   = 9,
    parameter int TICK_DIV = 8680,
    parameter int PROG_SEL = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       halted
);

    import byteprog_pkg::*;

    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_q;
    logic              tick;
    logic              tick_clr;
    seq_state_t        ctrl_state;
    logic [7:0]        ctrl_dcnt;

    byteprog_rom #(.ADDR_W(ADDR_W), .PROG_SEL(PROG_SEL)) u_rom (
        .clk   (clk),
        .addr  (rom_addr),
        .rdata (rom_q)
    );

    byteprog_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    byteprog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_q    (rom_q),
        .rom_addr (rom_addr),
        .tick     (tick),
        .tick_clr (tick_clr),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .halted   (halted),
        .state_o  (ctrl_state),
        .dcnt_o   (ctrl_dcnt)
    );

endmodule

// File: rtl/byteprog_seq_chk.sv
// Protocol checker for the byte-program sequencer, bound to its top.
// Assumes it sees the controller state and pause count from the top.
module byteprog_seq_chk
    import byteprog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       halted,
    input seq_state_t ctrl_state,
    input logic [7:0] ctrl_dcnt,
    input logic       tick
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !halted));

    // R2
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_WAIT && !tick) |=> $stable(ctrl_dcnt));

    // R2
    pause_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_WAIT && tick && !halted) |=> (ctrl_dcnt == $past(ctrl_dcnt) - 8'd1));

    // R3
    no_terminator_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data != TEXT_END));

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4
    offer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R5
    halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !tx_valid);

endmodule

bind byteprog_seq byteprog_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .halted     (halted),
    .ctrl_state (ctrl_state),
    .ctrl_dcnt  (ctrl_dcnt),
    .tick       (tick)
);

// File: tb/byteprog_seq_tb_top.sv
// Bench: two sequencers (stop-terminated and undefined-opcode programs)
// against a behavioural cycle model, compared on every falling edge.
module byteprog_seq_tb_top;

    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_ready = 1'b0;
    logic [7:0] d_o [2];
    logic       v_o [2];
    logic       h_o [2];

    int total = 0;
    int bad   = 0;

    logic       exp_v [2] = '{1'b0, 1'b0};
    logic [7:0] exp_d [2] = '{8'h00, 8'h00};
    logic       exp_h [2] = '{1'b0, 1'b0};
    logic       started [2] = '{1'b0, 1'b0};
    logic       done [2] = '{1'b0, 1'b0};
    string      tag [2] = '{"R1", "R1"};

    logic [7:0] got_a [$];
    logic [7:0] got_b [$];

    logic [7:0] prog_a [$] = '{8'hF1, 8'h03, 8'hF2, 8'h48, 8'h69, 8'h00,
                               8'hF1, 8'h00, 8'hF2, 8'h00, 8'hF1, 8'h01,
                               8'hF2, 8'h47, 8'h6F, 8'h21, 8'h00, 8'hF0,
                               8'hF2, 8'h58, 8'h00};
    logic [7:0] prog_b [$] = '{8'hF1, 8'h02, 8'hF2, 8'h41, 8'h62, 8'h00,
                               8'h7E, 8'hF2, 8'h5A, 8'h00};

    always #5 clk = ~clk;

    byteprog_seq #(.ADDR_W(9), .TICK_DIV(DIV), .PROG_SEL(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_data(d_o[0]), .tx_valid(v_o[0]),
        .tx_ready(tx_ready), .halted(h_o[0])
    );

    byteprog_seq #(.ADDR_W(9), .TICK_DIV(DIV), .PROG_SEL(1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .tx_data(d_o[1]), .tx_valid(v_o[1]),
        .tx_ready(tx_ready), .halted(h_o[1])
    );

    function automatic logic [7:0] prog_at(input int k, input int a);
        if (k == 0) return (a < prog_a.size()) ? prog_a[a] : 8'h00;
        return (a < prog_b.size()) ? prog_b[a] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_val, input string what);
        total++;
        if (act !== exp_val) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp_val, $time);
        end
    endtask

    // Behavioural model: walks the program and counts the cycle cost of each step.
    task automatic run_model(input int k);
        int pc = 0;
        wait (rst_n === 1'b1);
        @(posedge clk);
        started[k] = 1'b1;
        forever begin
            logic [7:0] op;
            op = prog_at(k, pc);
            if (op == 8'hF1) begin
                int n;
                n = int'(prog_at(k, pc + 1));
                pc += 2;
                tag[k] = "R2";
                repeat (4 + n * DIV) @(posedge clk);
            end else if (op == 8'hF2) begin
                pc++;
                tag[k] = "R3";
                repeat (2) @(posedge clk);
                forever begin
                    logic [7:0] ch;
                    ch = prog_at(k, pc);
                    @(posedge clk);
                    if (ch == 8'h00) begin
                        pc++;
                        @(posedge clk);
                        break;
                    end
                    exp_v[k] = 1'b1;
                    exp_d[k] = ch;
                    tag[k] = "R4";
                    do @(posedge clk); while (tx_ready !== 1'b1);
                    exp_v[k] = 1'b0;
                    tag[k] = "R3";
                    pc++;
                    @(posedge clk);
                end
            end else begin
                @(posedge clk);
                exp_h[k] = 1'b1;
                tag[k] = (op == 8'hF0) ? "R5" : "R6";
                done[k] = 1'b1;
                break;
            end
        end
    endtask

    initial run_model(0);
    initial run_model(1);

    // Irregular ready pattern from a 16-bit LFSR, driven on falling edges.
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready <= (lfsr[1:0] != 2'b00);
    end

    // Collect accepted characters at each handshake edge.
    always @(posedge clk) begin
        if (rst_n && v_o[0] && tx_ready) got_a.push_back(d_o[0]);
        if (rst_n && v_o[1] && tx_ready) got_b.push_back(d_o[1]);
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (started[k]) begin
                check(tag[k], 32'(v_o[k]), 32'(exp_v[k]), "tx_valid");
                if (exp_v[k]) check(tag[k], 32'(d_o[k]), 32'(exp_d[k]), "tx_data");
                check(exp_h[k] ? tag[k] : (k == 0 ? "R5" : "R6"), 32'(h_o[k]), 32'(exp_h[k]), "halted");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=halted");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check("R1", 32'(v_o[0]), 32'd0, "tx_valid in reset");
        check("R1", 32'(h_o[0]), 32'd0, "halted in reset");
        check("R1", 32'(v_o[1]), 32'd0, "tx_valid in reset (b)");
        check("R1", 32'(h_o[1]), 32'd0, "halted in reset (b)");
        rst_n = 1'b1;
        wait (done[0] === 1'b1 && done[1] === 1'b1);
        repeat (40) @(negedge clk);
        // R3: text streams, terminators dropped, empty string yields nothing
        check("R3", 32'(got_a.size()), 32'd5, "chars accepted (main)");
        if (got_a.size() == 5) begin
            check("R3", {got_a[0], got_a[1], got_a[2], got_a[3]}, 32'h4869476F, "text main");
            check("R3", 32'(got_a[4]), 32'h21, "last char main");
        end
        // R5: bytes after the stop never appear; R6: undefined opcode stops
        check("R5", 32'(h_o[0]), 32'd1, "halted stays high");
        check("R6", 32'(got_b.size()), 32'd2, "chars accepted (alt)");
        if (got_b.size() == 2) check("R6", {got_b[0], got_b[1]}, 32'h4162, "text alt");
        check("R6", 32'(h_o[1]), 32'd1, "halted on undefined opcode");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule